// File: doc/BRIEF.md
# TLB Access Rights Fault Checker

This block takes the result of a translation lookaside buffer lookup and decides what a memory access may do. From the current privilege level, the kind of access (read, write, execute, or an untyped debug probe) and a physical-mode flag, it produces a physical address, a three-bit permission mask and a four-bit fault code. All of these are computed in one combinational stage. A parameter selects whether they are then registered or passed straight through.

The permission mask is built from two parts. The first is the entry's rights type. The second is a pair of privilege limits, where a lower number means more privilege: an upper limit for reads and a lower limit for writes. Execute is allowed only when the privilege lies between the two limits.

After the mask is built, the dirty, break and trap-on-reference flags are applied in a fixed order, and each later check overrides the fault code of an earlier one. These checks also remove permission bits. A cached translation that reuses the returned mask is therefore sent back to the checker on its next access of the stripped kind.

Top module: `tlb_rights_checker`

## Requirements
- R1: While `rst_n` is low, `out_pa`, `out_perm` and `out_fault` are all zero.
- R2: When `phys_mode` is 1, the physical address equals the virtual address, the mask is 3'b111 and the fault is 0, whatever the lookup says.
- R3: Outside physical mode, when `lk_hit` or `lk_valid` is 0, the address is 0, the mask is 0 and the fault is 1 (translation miss). This holds for every access kind, including execute and debug.
- R4: On a valid hit, the physical address is `ent_frame` concatenated above the low `PAGE_BITS` bits of `va`.
- R5: Mask and kind bits are bit 0 read, bit 1 write and bit 2 execute. With privilege p, read is a candidate when p <= `ent_pl_rd`, write when p <= `ent_pl_wr`, and execute when `ent_pl_wr` <= p <= `ent_pl_rd`.
- R6: The rights type gates the candidates as follows: 0 allows read only, 1 allows read and write, 2 allows read and execute, 3 allows all three, and 4 to 7 allow execute only.
- R7: When `acc_kind` is 3'b000 (debug), there is no fault and the mask from R5/R6 is returned without any stripping.
- R8: When the requested kind is not in the mask, the R5/R6 mask is returned unchanged and no later check runs. The fault is 2 for an execute request, 3 if read is allowed, and 4 otherwise.
- R9: When `ent_dirty` is 0, the write bit is removed, and a write request gets fault 5. When `ent_brk` is 1, the write bit is removed, and a write request gets fault 6, which overrides fault 5.
- R10: When `ent_trap` is 1, only the execute bit is kept. Any non-execute request gets fault 7, which overrides faults 5 and 6.
- R11: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| phys_mode | input | 1 | Translation disabled; address passes through |
| va | input | VA_W | Virtual address of the access |
| lk_hit | input | 1 | Lookup found an entry covering `va` |
| lk_valid | input | 1 | Found entry is marked valid |
| ent_frame | input | PA_W-PAGE_BITS | Physical page number of the entry |
| ent_type | input | TYPE_W | Rights type of the entry |
| ent_pl_rd | input | PRIV_W | Least privilege allowed to read |
| ent_pl_wr | input | PRIV_W | Least privilege allowed to write |
| ent_dirty | input | 1 | Page already written |
| ent_brk | input | 1 | Break on write |
| ent_trap | input | 1 | Trap on data reference |
| priv | input | PRIV_W | Current privilege level (0 is most privileged) |
| acc_kind | input | 3 | One-hot access kind, 0 for debug |
| out_pa | output | PA_W | Physical address |
| out_perm | output | 3 | Permission mask {exec, write, read} |
| out_fault | output | 4 | Fault code, 0 for none |

## Verification
The bench sweeps every combination of privilege, both limits, rights type and access kind. This exposes an execute window that checks only one bound, or a type decode that lets types 4 to 7 grant read; either mistake shows up as a wrong mask.

Random entries with the dirty, break and trap flags mixed together probe the order of the overrides. A design that resolves them by forward priority would report a dirty fault where a break or reference fault is due. A design that strips bits after a protection fault would return a narrower mask than expected.

Directed cases cover a miss during an instruction fetch and a debug probe. A design that reports an instruction-side miss, or that applies flag checks to debug probes, fails these. They also cover a debug probe on a trapping page, which must keep its full mask.

// File: rtl/tlbrc_pkg.sv
package tlbrc_pkg;

   // Bit positions shared by the permission mask and the access kind
   localparam int BIT_RD = 0;
   localparam int BIT_WR = 1;
   localparam int BIT_EX = 2;

   typedef enum logic [3:0] {
      FLT_NONE        = 4'd0,
      FLT_TLB_MISS    = 4'd1,
      FLT_INSN_PROT   = 4'd2,
      FLT_DATA_PROT   = 4'd3,
      FLT_DATA_RIGHTS = 4'd4,
      FLT_DIRTY       = 4'd5,
      FLT_BREAK       = 4'd6,
      FLT_PAGE_REF    = 4'd7
   } fault_e;

endpackage

// File: rtl/tlbrc_perm.sv
// Builds the raw permission mask from the rights type and privilege limits.
module tlbrc_perm #(
   parameter int PRIV_W = 2,
   parameter int TYPE_W = 3
) (
   input  logic [PRIV_W-1:0] priv,
   input  logic [PRIV_W-1:0] pl_rd,
   input  logic [PRIV_W-1:0] pl_wr,
   input  logic [TYPE_W-1:0] rtype,
   output logic [2:0]        mask
);
   import tlbrc_pkg::*;

   logic can_rd, can_wr, can_ex;
   logic exec_only;

   assign can_rd = (priv <= pl_rd);
   assign can_wr = (priv <= pl_wr);
   assign can_ex = (pl_wr <= priv) && (priv <= pl_rd);

   generate
      if (TYPE_W > 2) begin : g_wide_type
         assign exec_only = |rtype[TYPE_W-1:2];
      end else begin : g_narrow_type
         assign exec_only = 1'b0;
      end
   endgenerate

   always_comb begin
      mask = 3'b000;
      if (exec_only) begin
         mask[BIT_EX] = can_ex;
      end else begin
         mask[BIT_RD] = can_rd;
         mask[BIT_WR] = can_wr & rtype[0];
         mask[BIT_EX] = can_ex & rtype[1];
      end
   end

endmodule

// File: rtl/tlbrc_fault.sv
// Resolves the fault code and strips permission bits in reverse priority.
module tlbrc_fault (
   input  logic [2:0] base_mask,
   input  logic [2:0] kind,
   input  logic       ent_d,
   input  logic       ent_b,
   input  logic       ent_t,
   output logic [2:0] mask,
   output logic [3:0] fault
);
   import tlbrc_pkg::*;

   fault_e f;

   always_comb begin
      f    = FLT_NONE;
      mask = base_mask;
      if (kind != 3'b000) begin
         if ((kind & base_mask) == 3'b000) begin
            if (kind[BIT_EX])          f = FLT_INSN_PROT;
            else if (base_mask[BIT_RD]) f = FLT_DATA_PROT;
            else                        f = FLT_DATA_RIGHTS;
         end else begin
            if (!ent_d) begin
               if (kind[BIT_WR]) f = FLT_DIRTY;
               mask[BIT_WR] = 1'b0;
            end
            if (ent_b) begin
               if (kind[BIT_WR]) f = FLT_BREAK;
               mask[BIT_WR] = 1'b0;
            end
            if (ent_t) begin
               if (!kind[BIT_EX]) f = FLT_PAGE_REF;
               mask[BIT_RD] = 1'b0;
               mask[BIT_WR] = 1'b0;
            end
         end
      end
   end

   assign fault = f;

endmodule

// File: rtl/tlbrc_addr.sv
// Forms the physical address for physical mode, hit or miss.
module tlbrc_addr #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic                   phys_mode,
   input  logic                   entry_ok,
   input  logic [VA_W-1:0]        va,
   input  logic [PA_W-PAGE_BITS-1:0] frame,
   output logic [PA_W-1:0]        pa
);
   logic [PA_W-1:0] va_fit;

   generate
      if (PA_W == VA_W) begin : g_same
         assign va_fit = va;
      end else if (PA_W > VA_W) begin : g_widen
         assign va_fit = {{(PA_W-VA_W){1'b0}}, va};
      end else begin : g_narrow
         assign va_fit = va[PA_W-1:0];
      end
   endgenerate

   always_comb begin
      if (phys_mode)     pa = va_fit;
      else if (entry_ok) pa = {frame, va[PAGE_BITS-1:0]};
      else               pa = '0;
   end

endmodule

// File: rtl/tlb_rights_checker.sv
module tlb_rights_checker #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PRIV_W    = 2,
   parameter int TYPE_W    = 3,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      phys_mode,
   input  logic [VA_W-1:0]           va,
   input  logic                      lk_hit,
   input  logic                      lk_valid,
   input  logic [PA_W-PAGE_BITS-1:0] ent_frame,
   input  logic [TYPE_W-1:0]         ent_type,
   input  logic [PRIV_W-1:0]         ent_pl_rd,
   input  logic [PRIV_W-1:0]         ent_pl_wr,
   input  logic                      ent_dirty,
   input  logic                      ent_brk,
   input  logic                      ent_trap,
   input  logic [PRIV_W-1:0]         priv,
   input  logic [2:0]                acc_kind,
   output logic [PA_W-1:0]           out_pa,
   output logic [2:0]                out_perm,
   output logic [3:0]                out_fault
);
   import tlbrc_pkg::*;

   localparam int FRAME_W = PA_W - PAGE_BITS;

   generate
      if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
         $error("PAGE_BITS must be below both address widths");
      end
      if (PRIV_W < 1) begin : g_bad_priv
         $error("PRIV_W must be at least 1");
      end
      if (TYPE_W < 2) begin : g_bad_type
         $error("TYPE_W must be at least 2");
      end
   endgenerate

   logic            entry_ok;
   logic [2:0]      base_mask, chk_mask, nxt_mask;
   logic [3:0]      chk_fault, nxt_fault;
   logic [PA_W-1:0] nxt_pa;

   assign entry_ok = lk_hit & lk_valid;

   tlbrc_perm #(.PRIV_W(PRIV_W), .TYPE_W(TYPE_W)) u_perm (
      .priv (priv),
      .pl_rd(ent_pl_rd),
      .pl_wr(ent_pl_wr),
      .rtype(ent_type),
      .mask (base_mask)
   );

   tlbrc_fault u_fault (
      .base_mask(base_mask),
      .kind     (acc_kind),
      .ent_d    (ent_dirty),
      .ent_b    (ent_brk),
      .ent_t    (ent_trap),
      .mask     (chk_mask),
      .fault    (chk_fault)
   );

   tlbrc_addr #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_addr (
      .phys_mode(phys_mode),
      .entry_ok (entry_ok),
      .va       (va),
      .frame    (ent_frame[FRAME_W-1:0]),
      .pa       (nxt_pa)
   );

   always_comb begin
      if (phys_mode) begin
         nxt_mask  = 3'b111;
         nxt_fault = FLT_NONE;
      end else if (!entry_ok) begin
         nxt_mask  = 3'b000;
         nxt_fault = FLT_TLB_MISS;
      end else begin
         nxt_mask  = chk_mask;
         nxt_fault = chk_fault;
      end
   end

   logic primed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_pa    <= '0;
               out_perm  <= 3'b000;
               out_fault <= 4'd0;
            end else begin
               out_pa    <= nxt_pa;
               out_perm  <= nxt_mask;
               out_fault <= nxt_fault;
            end
         end

         // R11
         latency_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed_q |-> (out_fault == $past(nxt_fault) && out_perm == $past(nxt_mask)));
      end else begin : g_comb
         always_comb begin
            out_pa    = rst_n ? nxt_pa    : '0;
            out_perm  = rst_n ? nxt_mask  : 3'b000;
            out_fault = rst_n ? nxt_fault : 4'd0;
         end
      end
   endgenerate

   // Access kind must be one-hot or zero
   kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_kind));

   // R2
   phys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_mode |-> (nxt_mask == 3'b111 && nxt_fault == 4'd0));

   // R3
   miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode && !entry_ok) |-> (nxt_mask == 3'b000 && nxt_fault == 4'd1 && nxt_pa == '0));

   // R7
   debug_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode && entry_ok && acc_kind == 3'b000) |-> (nxt_fault == 4'd0 && nxt_mask == base_mask));

   // R8
   prot_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode && entry_ok && acc_kind != 3'b000 && (acc_kind & base_mask) == 3'b000)
      |-> (nxt_fault inside {4'd2, 4'd3, 4'd4} && nxt_mask == base_mask));

   // R9
   write_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode && entry_ok && acc_kind != 3'b000 && (acc_kind & base_mask) != 3'b000
       && (!ent_dirty || ent_brk)) |-> !nxt_mask[BIT_WR]);

   // R10
   trap_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phys_mode && entry_ok && acc_kind != 3'b000 && (acc_kind & base_mask) != 3'b000
       && ent_trap) |-> (nxt_mask[1:0] == 2'b00));

endmodule

// File: tb/tlb_rights_checker_test.sv
module tlb_rights_checker_test;

   localparam int VA_W = 32;
   localparam int PA_W = 32;
   localparam int PB   = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            phys_mode = 1'b0;
   logic [VA_W-1:0] va = '0;
   logic            lk_hit = 1'b0, lk_valid = 1'b0;
   logic [PA_W-PB-1:0] ent_frame = '0;
   logic [2:0]      ent_type = '0;
   logic [1:0]      ent_pl_rd = '0, ent_pl_wr = '0, priv = '0;
   logic            ent_dirty = 1'b0, ent_brk = 1'b0, ent_trap = 1'b0;
   logic [2:0]      acc_kind = '0;
   logic [PA_W-1:0] out_pa;
   logic [2:0]      out_perm;
   logic [3:0]      out_fault;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [PA_W-1:0] exp_pa;
   logic [2:0]      exp_perm;
   int              exp_fault;

   always #5 clk = ~clk;

   tlb_rights_checker uut (
      .clk(clk), .rst_n(rst_n), .phys_mode(phys_mode), .va(va),
      .lk_hit(lk_hit), .lk_valid(lk_valid), .ent_frame(ent_frame),
      .ent_type(ent_type), .ent_pl_rd(ent_pl_rd), .ent_pl_wr(ent_pl_wr),
      .ent_dirty(ent_dirty), .ent_brk(ent_brk), .ent_trap(ent_trap),
      .priv(priv), .acc_kind(acc_kind),
      .out_pa(out_pa), .out_perm(out_perm), .out_fault(out_fault)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // Behavioural reference model from the requirements
   task automatic model();
      int p, lr, lw;
      bit r, w, x;
      bit want_r, want_w, want_x;
      p = priv; lr = ent_pl_rd; lw = ent_pl_wr;
      if (phys_mode) begin
         exp_pa = va; exp_perm = 3'b111; exp_fault = 0;
         return;
      end
      if (!(lk_hit && lk_valid)) begin
         exp_pa = '0; exp_perm = 3'b000; exp_fault = 1;
         return;
      end
      exp_pa = {ent_frame, va[PB-1:0]};
      want_r = (p <= lr);
      want_w = (p <= lw);
      want_x = (lw <= p) && (p <= lr);
      r = 0; w = 0; x = 0;
      case (int'(ent_type))
         0: r = want_r;
         1: begin r = want_r; w = want_w; end
         2: begin r = want_r; x = want_x; end
         3: begin r = want_r; w = want_w; x = want_x; end
         default: x = want_x;
      endcase
      exp_fault = 0;
      if (acc_kind != 0) begin
         if (!((acc_kind[0] && r) || (acc_kind[1] && w) || (acc_kind[2] && x))) begin
            exp_fault = acc_kind[2] ? 2 : (r ? 3 : 4);
         end else begin
            if (!ent_dirty) begin
               if (acc_kind[1]) exp_fault = 5;
               w = 0;
            end
            if (ent_brk) begin
               if (acc_kind[1]) exp_fault = 6;
               w = 0;
            end
            if (ent_trap) begin
               if (!acc_kind[2]) exp_fault = 7;
               r = 0; w = 0;
            end
         end
      end
      exp_perm = {x, w, r};
   endtask

   task automatic compare(input string tag);
      checks++;
      if (out_pa !== exp_pa || out_perm !== exp_perm || out_fault !== 4'(exp_fault)) begin
         fails++;
         $display("FAIL %s: pa=%h perm=%b fault=%0d expected pa=%h perm=%b fault=%0d",
                  tag, out_pa, out_perm, out_fault, exp_pa, exp_perm, exp_fault);
      end
   endtask

   // Called at a falling edge: inputs already set; sample one clock later.
   task automatic step(input string tag);
      model();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic set_entry(input bit hit, input bit vld, input logic [2:0] ty,
                            input logic [1:0] lr, input logic [1:0] lw,
                            input bit d, input bit b, input bit t);
      phys_mode = 1'b0;
      lk_hit = hit; lk_valid = vld; ent_type = ty;
      ent_pl_rd = lr; ent_pl_wr = lw;
      ent_dirty = d; ent_brk = b; ent_trap = t;
   endtask

   function automatic logic [2:0] kind_of(input int k);
      case (k)
         1: return 3'b001;
         2: return 3'b010;
         3: return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   initial begin
      // R1: reset state with active inputs
      phys_mode = 1'b1; va = 32'hDEAD_BEEF; acc_kind = 3'b001;
      repeat (3) @(negedge clk);
      exp_pa = '0; exp_perm = 3'b000; exp_fault = 0;
      compare("R1");
      rst_n = 1'b1;

      // R2: physical mode ignores a missing entry
      lk_hit = 1'b0; va = 32'h1234_5678; acc_kind = 3'b010;
      step("R2");
      va = 32'hFFFF_F000; acc_kind = 3'b100; lk_hit = 1'b1; lk_valid = 1'b1; ent_trap = 1'b1;
      step("R2");

      // R3: miss and invalid entry, fetch and debug kinds
      set_entry(0, 1, 3'd3, 2'd3, 2'd0, 1, 0, 0); va = 32'h0000_4321; acc_kind = 3'b100;
      step("R3");
      set_entry(1, 0, 3'd3, 2'd3, 2'd0, 1, 0, 0); acc_kind = 3'b000;
      step("R3");

      // R4: address composition
      set_entry(1, 1, 3'd1, 2'd3, 2'd3, 1, 0, 0);
      ent_frame = 20'hABCDE; va = 32'h7777_7F3A; priv = 2'd1; acc_kind = 3'b001;
      step("R4");

      // R7: debug probe on trapping, clean, break page keeps full mask
      set_entry(1, 1, 3'd3, 2'd3, 2'd0, 0, 1, 1); priv = 2'd2; acc_kind = 3'b000;
      step("R7");

      // R8: each protection fault
      set_entry(1, 1, 3'd0, 2'd3, 2'd3, 1, 0, 0); priv = 2'd0; acc_kind = 3'b100;
      step("R8");
      acc_kind = 3'b010;
      step("R8");
      set_entry(1, 1, 3'd4, 2'd3, 2'd0, 1, 0, 0); priv = 2'd1; acc_kind = 3'b001;
      step("R8");

      // R9: dirty fault then break overriding it
      set_entry(1, 1, 3'd1, 2'd3, 2'd3, 0, 0, 0); priv = 2'd0; acc_kind = 3'b010;
      step("R9");
      ent_brk = 1'b1;
      step("R9");
      acc_kind = 3'b001;
      step("R9");

      // R10: reference fault overrides, exec passes with exec-only mask
      set_entry(1, 1, 3'd3, 2'd3, 2'd0, 0, 1, 1); priv = 2'd0; acc_kind = 3'b010;
      step("R10");
      acc_kind = 3'b100;
      step("R10");

      // R11: back-to-back changes, each seen exactly one cycle later
      for (int i = 0; i < 8; i++) begin
         set_entry(1, 1, 3'(i), 2'd3, 2'd0, i[0], 0, 0);
         va = 32'(i * 32'h1111_1111); acc_kind = kind_of(i % 4);
         step("R11");
      end

      // R5 R6: full sweep of privilege, limits, type and kind
      for (int ty = 0; ty < 8; ty++)
         for (int lr = 0; lr < 4; lr++)
            for (int lw = 0; lw < 4; lw++)
               for (int p = 0; p < 4; p++)
                  for (int k = 0; k < 4; k++) begin
                     set_entry(1, 1, 3'(ty), 2'(lr), 2'(lw), 1, 0, 0);
                     priv = 2'(p); acc_kind = kind_of(k);
                     va = 32'(ty * 4096 + lr * 256 + p);
                     step("R5 R6");
                  end

      // R8 R9 R10: random entries with flags mixed
      for (int n = 0; n < 1500; n++) begin
         set_entry(($urandom % 16) != 0, ($urandom % 16) != 0, 3'($urandom),
                   2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         phys_mode = (($urandom % 32) == 0);
         priv = 2'($urandom); acc_kind = kind_of(int'($urandom % 4));
         va = $urandom; ent_frame = 20'($urandom);
         step("R8 R9 R10");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule